// File: doc/BRIEF.md
# DMA Translation Table Update Engine

This block carries out maintenance commands against a set of DMA address translation tables. A command selects a table by its identifier and gives an I/O bus address, a value or list pointer, and a page count. It asks for one of four operations. Single write stores one entry. Single read returns one entry. Fill stores one value into a run of consecutive pages. List write stores a run of entries whose values are fetched from memory. The table storage sits outside the block and is reached through a simple port: the write is committed on the same cycle, and read data arrives on the cycle after the read strobe.

Each configured table has four compile-time parameters: a 32-bit identifier, a bus offset, a page shift and an entry count. The bus address first has its low page-shift bits cleared. The entry index is then the aligned address minus the table's bus offset, shifted right by the page shift. Every stored entry raises a one-cycle invalidate pulse that carries its page-aligned bus address, so downstream translation caches can drop stale entries.

Commands enter on a valid/ready channel. `cmd_ready` stays low from acceptance until the response has been taken, so only one command is in flight at a time. A response is held, with stable status and data, until `rsp_ready` is high on a clock edge. List fetches use a valid/ready request channel. The block holds the request address steady while `mem_req_ready` is low and keeps one fetch outstanding. The one-cycle read answer on `mem_rsp_valid` cannot be stalled.

Top module: `xlat_table_updater`

## Requirements
- R1: A table identifier with any of bits 63:32 set, or whose low 32 bits match no configured table, yields status 1 (parameter error), with no table write, no memory fetch and no invalidate.
- R2: A write clears the low page-shift bits of the bus address and stores the value at index ((aligned address - bus offset) >> page shift) of the selected table; status 0 means success. Op codes: 0 single write, 1 single read, 2 fill, 3 list write.
- R3: An index at or beyond the table's entry count, including an address below the bus offset, yields status 1 and no write for that entry.
- R4: A successful single read returns status 0 and the stored 64-bit entry unchanged on `rsp_data`.
- R5: A fill stores the command value into count entries at consecutive pages, starting at the aligned address, and returns status 0.
- R6: A fill whose count exceeds the table's entry count returns status 1 without writing.
- R7: Multi-entry commands stop at the first entry whose index is out of range and return status 1; the entries before it stay written.
- R8: A list write whose count exceeds 512, or whose pointer has any of bits 11:0 set, returns status 1 with no memory fetch.
- R9: A list write fetches word i at pointer + 8*i. The byte at the lowest address arrives on `mem_rsp_data[7:0]` and is the most significant byte of the entry (big-endian). Word i is stored to the i-th page.
- R10: Every table write raises `inv_valid` for that cycle only, with `inv_addr` set to the page-aligned bus address of the entry.
- R11: `busy` is high from the cycle after acceptance until the response is taken. `cmd_ready` is low throughout, and no table write or fetch occurs while idle.
- R12: A fill or list write with count 0 returns status 1 with no write and no fetch.
- R13: A pending response keeps `rsp_valid`, `rsp_status` and `rsp_data` stable until taken. A pending fetch request keeps `mem_req_valid` and `mem_req_addr` stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | Operation code (R2) |
| cmd_table | input | 64 | Table identifier |
| cmd_addr | input | 64 | I/O bus address |
| cmd_value | input | 64 | Entry value, or list pointer for list write |
| cmd_count | input | 32 | Page count for fill and list write |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_status | output | 1 | 0 success, 1 parameter error |
| rsp_data | output | 64 | Entry returned by a single read, else zero |
| busy | output | 1 | Command in progress |
| tbl_sel | output | 1 | Table selected for the storage access |
| tbl_idx | output | 16 | Entry index for the storage access |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_data | output | 64 | Entry written |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_data | input | 64 | Entry read, valid the cycle after tbl_rd_en |
| mem_req_valid | output | 1 | List word fetch request |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | 64 | Byte address of the list word |
| mem_rsp_valid | input | 1 | Fetched word valid |
| mem_rsp_data | input | 64 | Fetched word, lowest byte address in bits 7:0 |
| inv_valid | output | 1 | Invalidate pulse |
| inv_addr | output | 64 | Page-aligned bus address to invalidate |

## Verification
The checker holds several properties on every cycle. Any write lands inside the selected table's entry range, and each invalidate address is page-aligned for its table. Fetch addresses sit on 8-byte boundaries. Acceptance raises busy, and an idle block stays quiet on the storage and memory ports. Responses and fetch requests hold steady under back-pressure. The directed scenarios are needed for the rest: the index arithmetic and bus-offset handling, read data passing through unchanged, the big-endian byte order of list words, the early stop at the first out-of-range entry with its earlier writes kept, and the rejection rules for identifier, count and pointer alignment.

// File: rtl/xtu_pkg.sv
package xtu_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } xtu_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DECODE,
    S_WRITE,
    S_READ,
    S_RWAIT,
    S_FETCH,
    S_FWAIT,
    S_RESP
  } xtu_state_e;

  localparam logic STAT_OK  = 1'b0;
  localparam logic STAT_ERR = 1'b1;

endpackage

// File: rtl/xtu_table_match.sv
module xtu_table_match #(
  parameter int NTBL  = 2,
  parameter int AW    = 64,
  parameter int SHW   = 6,
  parameter int CW    = 32,
  parameter int SEL_W = 1,
  parameter logic [NTBL-1:0][31:0]   TBL_ID      = '0,
  parameter logic [NTBL-1:0][AW-1:0] TBL_OFS     = '0,
  parameter logic [NTBL-1:0][SHW-1:0] TBL_SHIFT  = '0,
  parameter logic [NTBL-1:0][CW-1:0] TBL_ENTRIES = '0
) (
  input  logic [AW-1:0]  id,
  output logic           hit,
  output logic [SEL_W-1:0] sel,
  output logic [AW-1:0]  ofs,
  output logic [SHW-1:0] shift,
  output logic [CW-1:0]  entries
);

  logic [NTBL-1:0] hit_vec;
  logic            upper_clear;

  assign upper_clear = (id[AW-1:32] == '0);

  for (genvar g = 0; g < NTBL; g++) begin : g_cmp
    assign hit_vec[g] = upper_clear && (id[31:0] == TBL_ID[g]);
  end

  always_comb begin
    hit     = 1'b0;
    sel     = '0;
    ofs     = '0;
    shift   = '0;
    entries = '0;
    for (int i = NTBL - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit     = 1'b1;
        sel     = SEL_W'(i);
        ofs     = TBL_OFS[i];
        shift   = TBL_SHIFT[i];
        entries = TBL_ENTRIES[i];
      end
    end
  end

endmodule

// File: rtl/xtu_index_calc.sv
module xtu_index_calc #(
  parameter int AW    = 64,
  parameter int SHW   = 6,
  parameter int CW    = 32,
  parameter int IDX_W = 16
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    ofs,
  input  logic [SHW-1:0]   shift,
  input  logic [CW-1:0]    entries,
  output logic [AW-1:0]    aligned,
  output logic [AW-1:0]    page,
  output logic [IDX_W-1:0] idx,
  output logic             in_range
);

  logic [AW-1:0] low_mask;
  logic [AW-1:0] rel;
  logic [AW-1:0] idx_full;

  assign page     = {{(AW-1){1'b0}}, 1'b1} << shift;
  assign low_mask = page - {{(AW-1){1'b0}}, 1'b1};
  assign aligned  = addr & ~low_mask;
  assign rel      = aligned - ofs;
  assign idx_full = rel >> shift;
  assign in_range = (idx_full < {{(AW-CW){1'b0}}, entries});
  assign idx      = idx_full[IDX_W-1:0];

endmodule

// File: rtl/xtu_byte_swap.sv
module xtu_byte_swap #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end

endmodule

// File: rtl/xlat_table_updater.sv
module xlat_table_updater
  import xtu_pkg::*;
#(
  parameter int NTBL      = 2,
  parameter int AW        = 64,
  parameter int DW        = 64,
  parameter int CW        = 32,
  parameter int SHW       = 6,
  parameter int IDX_W     = 16,
  parameter int LIST_MAX  = 512,
  parameter int LIST_ALGN = 12,
  parameter logic [NTBL-1:0][31:0]    TBL_ID      = {32'h8000_0001, 32'h1000_0000},
  parameter logic [NTBL-1:0][AW-1:0]  TBL_OFS     = {64'h0000_0000_4000_0000, 64'h0},
  parameter logic [NTBL-1:0][SHW-1:0] TBL_SHIFT   = {6'd16, 6'd12},
  parameter logic [NTBL-1:0][CW-1:0]  TBL_ENTRIES = {32'd8, 32'd16},
  localparam int SEL_W = (NTBL > 1) ? $clog2(NTBL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [AW-1:0]    cmd_table,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_value,
  input  logic [CW-1:0]    cmd_count,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_status,
  output logic [DW-1:0]    rsp_data,
  output logic             busy,
  output logic [SEL_W-1:0] tbl_sel,
  output logic [IDX_W-1:0] tbl_idx,
  output logic             tbl_wr_en,
  output logic [DW-1:0]    tbl_wr_data,
  output logic             tbl_rd_en,
  input  logic [DW-1:0]    tbl_rd_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             inv_valid,
  output logic [AW-1:0]    inv_addr
);

  localparam int WORD_BYTES = DW / 8;

  xtu_state_e        st_q;
  xtu_op_e           op_q;
  logic [AW-1:0]     id_q;
  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     fptr_q;
  logic [DW-1:0]     val_q;
  logic [DW-1:0]     wval_q;
  logic [DW-1:0]     rdat_q;
  logic [CW-1:0]     rem_q;
  logic              stat_q;

  logic              hit;
  logic [SEL_W-1:0]  sel;
  logic [AW-1:0]     ofs;
  logic [SHW-1:0]    shift;
  logic [CW-1:0]     entries;
  logic [AW-1:0]     aligned;
  logic [AW-1:0]     page;
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic [DW-1:0]     swapped;

  logic              list_bad;
  logic              fill_bad;

  xtu_table_match #(
    .NTBL(NTBL), .AW(AW), .SHW(SHW), .CW(CW), .SEL_W(SEL_W),
    .TBL_ID(TBL_ID), .TBL_OFS(TBL_OFS), .TBL_SHIFT(TBL_SHIFT),
    .TBL_ENTRIES(TBL_ENTRIES)
  ) u_match (
    .id      (id_q),
    .hit     (hit),
    .sel     (sel),
    .ofs     (ofs),
    .shift   (shift),
    .entries (entries)
  );

  xtu_index_calc #(
    .AW(AW), .SHW(SHW), .CW(CW), .IDX_W(IDX_W)
  ) u_index (
    .addr     (addr_q),
    .ofs      (ofs),
    .shift    (shift),
    .entries  (entries),
    .aligned  (aligned),
    .page     (page),
    .idx      (idx),
    .in_range (in_range)
  );

  xtu_byte_swap #(.DW(DW)) u_swap (
    .din  (mem_rsp_data),
    .dout (swapped)
  );

  assign fill_bad = (rem_q > entries) || (rem_q == '0);
  assign list_bad = (rem_q > CW'(LIST_MAX)) || (rem_q == '0) ||
                    (val_q[LIST_ALGN-1:0] != '0);

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_PUT;
      id_q   <= '0;
      addr_q <= '0;
      fptr_q <= '0;
      val_q  <= '0;
      wval_q <= '0;
      rdat_q <= '0;
      rem_q  <= '0;
      stat_q <= STAT_ERR;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q   <= xtu_op_e'(cmd_op);
            id_q   <= cmd_table;
            addr_q <= cmd_addr;
            val_q  <= cmd_value;
            rem_q  <= cmd_count;
            rdat_q <= '0;
            stat_q <= STAT_ERR;
            st_q   <= S_DECODE;
          end
        end

        S_DECODE: begin
          addr_q <= aligned;
          if (!hit) begin
            stat_q <= STAT_ERR;
            st_q   <= S_RESP;
          end else begin
            unique case (op_q)
              OP_PUT: begin
                rem_q  <= CW'(1);
                wval_q <= val_q;
                st_q   <= S_WRITE;
              end
              OP_GET: begin
                st_q <= in_range ? S_READ : S_RESP;
              end
              OP_FILL: begin
                wval_q <= val_q;
                st_q   <= fill_bad ? S_RESP : S_WRITE;
              end
              default: begin
                fptr_q <= val_q[AW-1:0];
                st_q   <= list_bad ? S_RESP : S_FETCH;
              end
            endcase
          end
        end

        S_WRITE: begin
          if (!in_range) begin
            stat_q <= STAT_ERR;
            st_q   <= S_RESP;
          end else begin
            rem_q  <= rem_q - CW'(1);
            addr_q <= addr_q + page;
            if (rem_q == CW'(1)) begin
              stat_q <= STAT_OK;
              st_q   <= S_RESP;
            end else if (op_q == OP_LIST) begin
              st_q <= S_FETCH;
            end
          end
        end

        S_READ: st_q <= S_RWAIT;

        S_RWAIT: begin
          rdat_q <= tbl_rd_data;
          stat_q <= STAT_OK;
          st_q   <= S_RESP;
        end

        S_FETCH: begin
          if (mem_req_ready) begin
            fptr_q <= fptr_q + AW'(WORD_BYTES);
            st_q   <= S_FWAIT;
          end
        end

        S_FWAIT: begin
          if (mem_rsp_valid) begin
            wval_q <= swapped;
            st_q   <= S_WRITE;
          end
        end

        S_RESP: begin
          if (rsp_ready) st_q <= S_IDLE;
        end

        default: st_q <= S_IDLE;
      endcase
    end
  end

  // Port drive
  assign busy          = (st_q != S_IDLE);
  assign cmd_ready     = (st_q == S_IDLE);
  assign rsp_valid     = (st_q == S_RESP);
  assign rsp_status    = stat_q;
  assign rsp_data      = rdat_q;

  assign tbl_sel       = sel;
  assign tbl_idx       = idx;
  assign tbl_wr_en     = (st_q == S_WRITE) && in_range;
  assign tbl_wr_data   = wval_q;
  assign tbl_rd_en     = (st_q == S_READ);

  assign mem_req_valid = (st_q == S_FETCH);
  assign mem_req_addr  = fptr_q;

  assign inv_valid     = tbl_wr_en;
  assign inv_addr      = addr_q;

endmodule

// File: rtl/xtu_checker.sv
module xtu_checker #(
  parameter int NTBL  = 2,
  parameter int AW    = 64,
  parameter int DW    = 64,
  parameter int CW    = 32,
  parameter int SHW   = 6,
  parameter int IDX_W = 16,
  parameter int SEL_W = 1,
  parameter logic [NTBL-1:0][SHW-1:0] TBL_SHIFT   = '0,
  parameter logic [NTBL-1:0][CW-1:0]  TBL_ENTRIES = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             busy,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_status,
  input logic [DW-1:0]    rsp_data,
  input logic [SEL_W-1:0] tbl_sel,
  input logic [IDX_W-1:0] tbl_idx,
  input logic             tbl_wr_en,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_req_addr,
  input logic             inv_valid,
  input logic [AW-1:0]    inv_addr
);

  logic [AW-1:0] sel_mask;
  logic [CW-1:0] sel_entries;

  assign sel_mask    = ({{(AW-1){1'b0}}, 1'b1} << TBL_SHIFT[tbl_sel]) - {{(AW-1){1'b0}}, 1'b1};
  assign sel_entries = TBL_ENTRIES[tbl_sel];

  p_wr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |-> ({{(CW-IDX_W){1'b0}}, tbl_idx} < sel_entries));

  p_inv_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> ((inv_addr & sel_mask) == '0));

  p_fetch_word_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tbl_wr_en && !mem_req_valid && !rsp_valid));

  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_data)));

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

endmodule

bind xlat_table_updater xtu_checker #(
  .NTBL(NTBL), .AW(AW), .DW(DW), .CW(CW), .SHW(SHW), .IDX_W(IDX_W),
  .SEL_W(SEL_W), .TBL_SHIFT(TBL_SHIFT), .TBL_ENTRIES(TBL_ENTRIES)
) u_xtu_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .busy          (busy),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_status    (rsp_status),
  .rsp_data      (rsp_data),
  .tbl_sel       (tbl_sel),
  .tbl_idx       (tbl_idx),
  .tbl_wr_en     (tbl_wr_en),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .inv_valid     (inv_valid),
  .inv_addr      (inv_addr)
);

// File: tb/tb_xlat_table_updater.sv
`timescale 1ns/1ps
module tb_xlat_table_updater;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [63:0] cmd_table = '0;
  logic [63:0] cmd_addr = '0;
  logic [63:0] cmd_value = '0;
  logic [31:0] cmd_count = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_status;
  logic [63:0] rsp_data;
  logic        busy;
  logic        tbl_sel;
  logic [15:0] tbl_idx;
  logic        tbl_wr_en;
  logic [63:0] tbl_wr_data;
  logic        tbl_rd_en;
  logic [63:0] tbl_rd_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        inv_valid;
  logic [63:0] inv_addr;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  int inv_count = 0;
  int fetch_count = 0;
  logic [63:0] last_inv = '0;
  logic        bp_en = 1'b0;
  logic [63:0] tmem [0:1][0:15];

  localparam logic [63:0] ID0 = 64'h1000_0000;
  localparam logic [63:0] ID1 = 64'h8000_0001;

  always #2 clk = ~clk;

  xlat_table_updater dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_table(cmd_table), .cmd_addr(cmd_addr), .cmd_value(cmd_value),
    .cmd_count(cmd_count),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .busy(busy),
    .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_wr_en(tbl_wr_en),
    .tbl_wr_data(tbl_wr_data), .tbl_rd_en(tbl_rd_en), .tbl_rd_data(tbl_rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  function automatic logic [63:0] list_word(input logic [63:0] a);
    return 64'hBEEF_0000_0000_0003 | {16'h0, a[15:0], a[31:0]};
  endfunction

  function automatic logic [63:0] to_bus(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  // Table storage and memory models
  always @(posedge clk) begin
    if (tbl_wr_en) begin
      tmem[tbl_sel][tbl_idx[3:0]] <= tbl_wr_data;
      wr_count <= wr_count + 1;
    end
    if (inv_valid) begin
      inv_count <= inv_count + 1;
      last_inv  <= inv_addr;
    end
    if (tbl_rd_en) tbl_rd_data <= tmem[tbl_sel][tbl_idx[3:0]];
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      fetch_count  <= fetch_count + 1;
      mem_rsp_data <= to_bus(list_word(mem_req_addr));
    end
  end

  always @(negedge clk) mem_req_ready <= bp_en ? ~mem_req_ready : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [63:0] id,
                         input logic [63:0] addr, input logic [63:0] val,
                         input logic [31:0] cnt, input int hold,
                         output logic st, output logic [63:0] dat);
    @(negedge clk);
    cmd_op = op; cmd_table = id; cmd_addr = addr; cmd_value = val;
    cmd_count = cnt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R11 busy after accept", {63'd0, busy}, 64'd1);
    while (!rsp_valid) @(negedge clk);
    st = rsp_status; dat = rsp_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_status == st && rsp_data == dat,
          "R13 response held", {63'd0, rsp_status}, {63'd0, st});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!busy && cmd_ready, "R11 idle after response", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_reset();
    chk(!busy && cmd_ready && !rsp_valid && !mem_req_valid && !tbl_wr_en,
        "R11 reset state", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_put_get();
    logic st; logic [63:0] d; int w0, i0;
    w0 = wr_count; i0 = inv_count;
    run_cmd(2'd0, ID0, 64'h3ABC, 64'h1234_5678_9ABC_DEF3, 0, 0, st, d);
    chk(st == 1'b0, "R2 put status", {63'd0, st}, 64'd0);
    chk(tmem[0][3] == 64'h1234_5678_9ABC_DEF3, "R2 put entry", tmem[0][3], 64'h1234_5678_9ABC_DEF3);
    chk(inv_count == i0 + 1 && last_inv == 64'h3000, "R10 invalidate addr", last_inv, 64'h3000);
    run_cmd(2'd1, ID0, 64'h3FFF, 0, 0, 2, st, d);
    chk(st == 1'b0 && d == 64'h1234_5678_9ABC_DEF3, "R4 get data", d, 64'h1234_5678_9ABC_DEF3);
    run_cmd(2'd0, ID1, 64'h4002_1234, 64'hCAFE_0000_0000_0001, 0, 0, st, d);
    chk(st == 1'b0 && tmem[1][2] == 64'hCAFE_0000_0000_0001, "R2 offset index", tmem[1][2], 64'hCAFE_0000_0000_0001);
    chk(last_inv == 64'h4002_0000 && wr_count == w0 + 2, "R10 offset invalidate", last_inv, 64'h4002_0000);
  endtask

  task automatic t_bad_index_id();
    logic st; logic [63:0] d; int w0, i0;
    w0 = wr_count; i0 = inv_count;
    run_cmd(2'd0, ID0, 64'h10000, 64'h77, 0, 0, st, d);
    chk(st == 1'b1, "R3 index beyond entries", {63'd0, st}, 64'd1);
    run_cmd(2'd0, ID1, 64'h3FFF_0000, 64'h77, 0, 0, st, d);
    chk(st == 1'b1, "R3 address below offset", {63'd0, st}, 64'd1);
    run_cmd(2'd1, ID0, 64'h20000, 0, 0, 0, st, d);
    chk(st == 1'b1, "R3 get out of range", {63'd0, st}, 64'd1);
    run_cmd(2'd0, 64'h1_1000_0000, 64'h1000, 64'h77, 0, 0, st, d);
    chk(st == 1'b1, "R1 upper id bits", {63'd0, st}, 64'd1);
    run_cmd(2'd2, 64'h5, 64'h1000, 64'h77, 2, 0, st, d);
    chk(st == 1'b1, "R1 unknown id", {63'd0, st}, 64'd1);
    chk(wr_count == w0 && inv_count == i0, "R1 R3 no writes", wr_count - w0, 64'd0);
  endtask

  task automatic t_fill();
    logic st; logic [63:0] d; int w0, i0; bit ok;
    w0 = wr_count; i0 = inv_count;
    run_cmd(2'd2, ID0, 64'hC123, 64'hF00D_0000_0000_0002, 4, 0, st, d);
    ok = 1'b1;
    for (int i = 12; i < 16; i++) if (tmem[0][i] != 64'hF00D_0000_0000_0002) ok = 1'b0;
    chk(st == 1'b0 && ok, "R5 fill entries", {63'd0, st}, 64'd0);
    chk(wr_count == w0 + 4 && inv_count == i0 + 4 && last_inv == 64'hF000,
        "R10 fill invalidates", last_inv, 64'hF000);
    w0 = wr_count;
    run_cmd(2'd2, ID0, 64'hE000, 64'h0BAD_0000_0000_0001, 4, 0, st, d);
    chk(st == 1'b1 && wr_count == w0 + 2, "R7 fill stops at range end", wr_count - w0, 64'd2);
    chk(tmem[0][14] == 64'h0BAD_0000_0000_0001 && tmem[0][15] == 64'h0BAD_0000_0000_0001,
        "R7 earlier entries kept", tmem[0][15], 64'h0BAD_0000_0000_0001);
    w0 = wr_count;
    run_cmd(2'd2, ID0, 64'h0, 64'h99, 17, 0, st, d);
    chk(st == 1'b1, "R6 fill count too large", {63'd0, st}, 64'd1);
    run_cmd(2'd2, ID0, 64'h0, 64'h99, 0, 0, st, d);
    chk(st == 1'b1 && wr_count == w0, "R12 fill zero count", wr_count - w0, 64'd0);
  endtask

  task automatic t_list();
    logic st; logic [63:0] d; int w0, f0; bit ok;
    w0 = wr_count; f0 = fetch_count;
    bp_en = 1'b1;
    run_cmd(2'd3, ID1, 64'h4001_0000, 64'h2000, 3, 0, st, d);
    bp_en = 1'b0;
    ok = (tmem[1][1] == list_word(64'h2000)) && (tmem[1][2] == list_word(64'h2008)) &&
         (tmem[1][3] == list_word(64'h2010));
    chk(st == 1'b0 && ok, "R9 list entries big-endian", tmem[1][2], list_word(64'h2008));
    chk(fetch_count == f0 + 3 && wr_count == w0 + 3, "R9 list fetch count", fetch_count - f0, 64'd3);
    w0 = wr_count; f0 = fetch_count;
    run_cmd(2'd3, ID1, 64'h4006_0000, 64'h3000, 4, 0, st, d);
    chk(st == 1'b1 && wr_count == w0 + 2 && tmem[1][7] == list_word(64'h3008),
        "R7 list stops at range end", wr_count - w0, 64'd2);
    w0 = wr_count; f0 = fetch_count;
    run_cmd(2'd3, ID1, 64'h4000_0000, 64'h2008, 2, 0, st, d);
    chk(st == 1'b1, "R8 misaligned pointer", {63'd0, st}, 64'd1);
    run_cmd(2'd3, ID1, 64'h4000_0000, 64'h2000, 513, 0, st, d);
    chk(st == 1'b1, "R8 count above limit", {63'd0, st}, 64'd1);
    run_cmd(2'd3, ID1, 64'h4000_0000, 64'h2000, 0, 0, st, d);
    chk(st == 1'b1 && fetch_count == f0 && wr_count == w0, "R12 list zero count",
        fetch_count - f0, 64'd0);
  endtask

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 16; i++) tmem[t][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_put_get();
    t_bad_index_id();
    t_fill();
    t_list();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule